// File: doc/BRIEF.md
# Cache Line Zeroing Engine

This engine clears one data cache line in memory. A start pulse hands it an address, a configured line length in bytes and a configuration word. The engine works out the effective line length and rounds the address down to that line boundary. It then walks the line from its lowest word upward, writing a zero 32-bit word at each step over a simple request/acknowledge write port.

The effective length is normally the configured one. A two-bit field inside the configuration word can force it to 32 bytes. The position of that field and the code that triggers the override are parameters, so builds with different field layouts reuse the same RTL. When the last word has been accepted, the engine raises done for one cycle and returns to idle. It holds only one write outstanding at a time.

Top module: `line_zero_engine`

## Requirements
- R1: The first write address equals the start address with its low bits cleared, using the mask (effective line bytes − 1).
- R2: Successive writes go to rising word offsets in steps of 4 bytes from the aligned base, and every write carries the data value 0.
- R3: A configured length of 32, 64 or 128 bytes produces exactly 8, 16 or 32 word writes respectively.
- R4: When cfg_word_i[MODE_LSB+1:MODE_LSB] equals OVR_CODE (defaults: bits 8:7, code 1), the effective length is 32 bytes whatever the configured length is. Any other value of that field leaves the configured length in force.
- R5: A configured length other than 32, 64 or 128 is treated as 32 bytes.
- R6: A write request stays asserted, with address and data stable, until it is acknowledged. Each acknowledged request advances by exactly one word.
- R7: done_o is high for exactly one cycle, namely the cycle after the cycle in which the last write was acknowledged. busy_o is low from the following cycle.
- R8: A start pulse that arrives while busy_o is high is ignored. The sequence in progress keeps its base, length and order.
- R9: While reset is held and right after it, busy_o, wr_req_o and done_o are low.
- R10: A start pulse seen while idle makes wr_req_o high in the next cycle. Address, length and configuration are captured at the start pulse, so later changes on those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to clear one line, sampled while idle |
| addr_i | input | ADDR_W | Any byte address inside the target line |
| line_bytes_i | input | SIZE_W | Configured line length in bytes |
| cfg_word_i | input | CFG_W | Configuration word holding the two-bit override field |
| wr_req_o | output | 1 | Write request, held until acknowledged |
| wr_addr_o | output | ADDR_W | Byte address of the word being written |
| wr_data_o | output | 32 | Write data, always zero |
| wr_ack_i | input | 1 | Acknowledge for the current write |
| busy_o | output | 1 | High from the cycle after start until done has been shown |
| done_o | output | 1 | One-cycle pulse after the last write is accepted |

## Verification
The bench aims at unaligned start addresses in lines of each length. A wrong mask would show up as a first write inside the line instead of at its boundary. It drives the override field with the trigger code, with a neighbouring code, and with the trigger code at the wrong bit position. A decoder that looked at the wrong bits would clear 64 or 128 bytes where 32 were due, or the reverse. Unsupported lengths such as 0, 16, 96 and 255 must fall back to eight writes; an engine that decoded only one bit of the length would produce a longer walk. Random acknowledge gaps, a start pulse injected mid-line, and input changes right after start check two things: a design that advanced without an acknowledge would skip an offset, and one that reloaded on the second start would jump to a foreign base.

// File: rtl/lzero_pkg.sv
// Package: shared constants and the controller state type for the
// line zeroing engine. Assumes 32-bit write words and lines of at most
// 128 bytes.
package lzero_pkg;
    localparam int WORD_BYTES     = 4;
    localparam int MAX_LINE_BYTES = 128;
    localparam int MAX_WORDS      = MAX_LINE_BYTES / WORD_BYTES;
    localparam int IDX_W          = $clog2(MAX_WORDS);
    localparam int DATA_W         = 8 * WORD_BYTES;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_FIN  = 2'd2
    } lz_state_t;
endpackage

// File: rtl/lzero_size_sel.sv
// Module: lzero_size_sel
// Purpose: turn the configured line length and the override field of the
// configuration word into an effective last-word index and an alignment
// mask. Purely combinational.
// Assumes: MODE_LSB+1 < CFG_W; the lengths 64 and 128 fit in SIZE_W bits.
module lzero_size_sel
    import lzero_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          SIZE_W   = 8,
    parameter int          CFG_W    = 32,
    parameter int          MODE_LSB = 7,
    parameter logic [1:0]  OVR_CODE = 2'd1
) (
    input  logic [SIZE_W-1:0] line_bytes_i,
    input  logic [CFG_W-1:0]  cfg_word_i,
    output logic [IDX_W-1:0]  last_idx_o,
    output logic [ADDR_W-1:0] mask_o
);
    localparam logic [SIZE_W-1:0] LEN_64  = SIZE_W'(64);
    localparam logic [SIZE_W-1:0] LEN_128 = SIZE_W'(128);

    logic [1:0] mode_fld;
    logic       force_small;
    logic [7:0] eff_bytes;

    // Extract the two-bit override field from its parameterised position.
    always_comb begin
        mode_fld    = cfg_word_i[MODE_LSB+1:MODE_LSB];
        force_small = (mode_fld == OVR_CODE);
    end

    // Pick the effective line length; anything unsupported falls to 32.
    always_comb begin
        if (force_small)                  eff_bytes = 8'd32;
        else if (line_bytes_i == LEN_64)  eff_bytes = 8'd64;
        else if (line_bytes_i == LEN_128) eff_bytes = 8'd128;
        else                              eff_bytes = 8'd32;
    end

    // Derive the last word index and the address alignment mask.
    always_comb begin
        last_idx_o = IDX_W'((eff_bytes >> 2) - 8'd1);
        mask_o     = ~(ADDR_W'(eff_bytes) - ADDR_W'(1));
    end
endmodule

// File: rtl/lzero_addr_gen.sv
// Module: lzero_addr_gen
// Purpose: hold the aligned line base and the word index, and form the
// byte address of the current write as base plus four times the index.
// Assumes: base_i is already aligned; load and inc never coincide.
module lzero_addr_gen
    import lzero_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              inc_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;

    // Capture the base on load and step the word index on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            base_q <= base_i;
            idx_q  <= '0;
        end else if (inc_i) begin
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    // Form the word address from base and index.
    always_comb begin
        idx_o  = idx_q;
        addr_o = base_q + (ADDR_W'(idx_q) << 2);
    end
endmodule

// File: rtl/lzero_ctrl.sv
// Module: lzero_ctrl
// Purpose: sequence one line clear: accept a start while idle, keep one
// write outstanding until acknowledged, stop after the last index and
// show done for a single cycle.
// Assumes: ack_i is only meaningful while req_o is high.
module lzero_ctrl
    import lzero_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ack_i,
    input  logic [IDX_W-1:0] last_idx_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             load_o,
    output logic             inc_o,
    output logic             req_o,
    output logic             done_o,
    output logic             busy_o
);
    lz_state_t        state_q, state_d;
    logic [IDX_W-1:0] last_q;

    // Next-state decision for the clear sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_FILL;
            ST_FILL: if (ack_i && (idx_i == last_q)) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and latched last index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load_o) last_q <= last_idx_i;
        end
    end

    // Decode controls and port strobes from the current state.
    always_comb begin
        load_o = (state_q == ST_IDLE) && start_i;
        inc_o  = (state_q == ST_FILL) && ack_i;
        req_o  = (state_q == ST_FILL);
        done_o = (state_q == ST_FIN);
        busy_o = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/line_zero_engine.sv
// Module: line_zero_engine
// Purpose: top of the line zeroing engine; ties the size selector, the
// controller and the address generator to a zero-data word write port.
// Assumes: one write outstanding; the memory side acknowledges each
// request in its own time while the request stays high.
module line_zero_engine
    import lzero_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          SIZE_W   = 8,
    parameter int          CFG_W    = 32,
    parameter int          MODE_LSB = 7,
    parameter logic [1:0]  OVR_CODE = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] line_bytes_i,
    input  logic [CFG_W-1:0]  cfg_word_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic              wr_ack_i,
    output logic              busy_o,
    output logic              done_o
);
    logic [IDX_W-1:0]  last_idx;
    logic [ADDR_W-1:0] mask;
    logic [IDX_W-1:0]  idx;
    logic              load;
    logic              inc;

    lzero_size_sel #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .CFG_W    (CFG_W),
        .MODE_LSB (MODE_LSB),
        .OVR_CODE (OVR_CODE)
    ) u_size (
        .line_bytes_i (line_bytes_i),
        .cfg_word_i   (cfg_word_i),
        .last_idx_o   (last_idx),
        .mask_o       (mask)
    );

    lzero_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ack_i      (wr_ack_i),
        .last_idx_i (last_idx),
        .idx_i      (idx),
        .load_o     (load),
        .inc_o      (inc),
        .req_o      (wr_req_o),
        .done_o     (done_o),
        .busy_o     (busy_o)
    );

    lzero_addr_gen #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .base_i (addr_i & mask),
        .inc_i  (inc),
        .idx_o  (idx),
        .addr_o (wr_addr_o)
    );

    // The engine only ever writes zero words.
    always_comb wr_data_o = '0;
endmodule

// File: rtl/line_zero_engine_chk.sv
// Module: line_zero_engine_chk
// Purpose: temporal checks on the write port and status outputs of the
// line zeroing engine, attached by bind.
// Assumes: the same ADDR_W as the engine instance it is bound to.
module line_zero_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              wr_req_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [31:0]       wr_data_o,
    input logic              wr_ack_i,
    input logic              busy_o,
    input logic              done_o
);
    // R6: an unacknowledged request stays up with the same address.
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o)));

    // R2: every request carries zero data on a word-aligned address.
    assert_zero_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (wr_data_o == 32'd0 && wr_addr_o[1:0] == 2'b00));

    // R2: an accepted write that is followed by another moves up by 4 bytes.
    assert_step_four_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_ack_i) |=> (!wr_req_o || wr_addr_o == $past(wr_addr_o) + ADDR_W'(4)));

    // R7: done follows an accepted write and lasts one cycle, then idle.
    assert_done_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_req_o && wr_ack_i));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R8: a start pulse during an unacknowledged write changes nothing.
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && wr_req_o && !wr_ack_i) |=> (wr_req_o && wr_addr_o == $past(wr_addr_o)));

    // R10: a start pulse while idle raises the request next cycle.
    assert_start_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> wr_req_o);
endmodule

bind line_zero_engine line_zero_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .wr_req_o  (wr_req_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_ack_i  (wr_ack_i),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/line_zero_engine_bench.sv
// Bench: directed corner cases plus seeded random line clears, each
// checked write by write against a model of the requirements.
module line_zero_engine_bench;
    localparam int         ADDR_W   = 32;
    localparam int         SIZE_W   = 8;
    localparam int         CFG_W    = 32;
    localparam int         MODE_LSB = 7;
    localparam logic [1:0] OVR_CODE = 2'd1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [SIZE_W-1:0] line_bytes_i = '0;
    logic [CFG_W-1:0]  cfg_word_i = '0;
    logic              wr_req_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [31:0]       wr_data_o;
    logic              wr_ack_i = 1'b0;
    logic              busy_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    line_zero_engine #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CFG_W(CFG_W),
        .MODE_LSB(MODE_LSB), .OVR_CODE(OVR_CODE)
    ) u_line_zero_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .line_bytes_i(line_bytes_i), .cfg_word_i(cfg_word_i),
        .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_ack_i(wr_ack_i), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Effective line bytes per R3, R4, R5.
    function automatic int eff_bytes(input logic [7:0] sz, input logic [31:0] cfg);
        if (cfg[MODE_LSB+1 -: 2] == OVR_CODE) return 32;
        if (sz == 8'd64)  return 64;
        if (sz == 8'd128) return 128;
        return 32;
    endfunction

    // One full line clear with random acknowledge gaps; optional mid-line start.
    task automatic run_op(input logic [31:0] a, input logic [7:0] sz,
                          input logic [31:0] cfg, input bit poke, input string tag);
        int          nexp;
        int          n;
        int          guard;
        bit          poked;
        logic [31:0] base;
        nexp  = eff_bytes(sz, cfg) / 4;
        base  = a & ~(32'(eff_bytes(sz, cfg)) - 32'd1);
        n     = 0;
        guard = 0;
        poked = 1'b0;
        @(negedge clk);
        start_i = 1'b1; addr_i = a; line_bytes_i = sz; cfg_word_i = cfg;
        @(negedge clk);
        start_i = 1'b0;
        addr_i = $urandom; line_bytes_i = 8'd128; cfg_word_i = $urandom;
        check(wr_req_o && busy_o, "R10 launch", {30'd0, busy_o, wr_req_o}, 32'd3);
        while (n < nexp && guard < 2000) begin
            guard++;
            wr_ack_i = 1'b0;
            start_i  = 1'b0;
            if (!wr_req_o) begin
                check(1'b0, {tag, " R6 request dropped"}, 32'd0, 32'd1);
                guard = 2000;
            end else begin
                check(wr_addr_o == base + 32'(4 * n) && wr_data_o == 32'd0 && !done_o,
                      n == 0 ? {tag, " R1 first address"} : {tag, " R2 offset"},
                      wr_addr_o, base + 32'(4 * n));
                if (poke && !poked && n == 2) begin
                    start_i = 1'b1; addr_i = ~a; poked = 1'b1; // R8
                end
                if ($urandom % 3 != 0) begin
                    wr_ack_i = 1'b1;
                    n++;
                end
            end
            @(negedge clk);
        end
        wr_ack_i = 1'b0;
        start_i  = 1'b0;
        // R3 word count, R7 done timing
        check(done_o && !wr_req_o, {tag, " R3 count / R7 done"},
              {30'd0, wr_req_o, done_o}, 32'd1);
        @(negedge clk);
        check(!done_o && !busy_o, {tag, " R7 single pulse"},
              {30'd0, busy_o, done_o}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy_o && !wr_req_o && !done_o, "R9 in reset",
              {29'd0, done_o, wr_req_o, busy_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !wr_req_o && !done_o, "R9 after reset",
              {29'd0, done_o, wr_req_o, busy_o}, 32'd0);

        // R3 each supported length with unaligned addresses
        run_op(32'h0000_1237, 8'd32,  32'h0, 1'b0, "R3 len32");
        run_op(32'h0000_40FF, 8'd64,  32'h0, 1'b0, "R3 len64");
        run_op(32'hFFFF_FFFF, 8'd128, 32'h0, 1'b0, "R3 len128");
        // R4 override code forces 32, neighbouring code does not
        run_op(32'h0000_207C, 8'd128, 32'h0000_0080, 1'b0, "R4 override");
        run_op(32'h0000_207C, 8'd128, 32'h0000_0100, 1'b0, "R4 code2 no override");
        run_op(32'h0000_207C, 8'd64,  32'h0000_0040, 1'b0, "R4 wrong bits");
        // R5 unsupported lengths
        run_op(32'h0000_3055, 8'd96,  32'h0, 1'b0, "R5 len96");
        run_op(32'h0000_3055, 8'd0,   32'h0, 1'b0, "R5 len0");
        run_op(32'h0000_3055, 8'd255, 32'h0, 1'b0, "R5 len255");
        run_op(32'h0000_3055, 8'd16,  32'h0, 1'b0, "R5 len16");
        // R8 start while busy
        run_op(32'h8000_0044, 8'd64,  32'h0, 1'b1, "R8 busy start");

        for (int i = 0; i < 40; i++) begin
            logic [7:0]  sz;
            logic [31:0] cfg;
            case ($urandom % 6)
                0: sz = 8'd32;
                1, 2: sz = 8'd64;
                3, 4: sz = 8'd128;
                default: sz = 8'($urandom);
            endcase
            cfg = $urandom;
            run_op($urandom, sz, cfg, ($urandom % 4) == 0, "R2 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule